// File: doc/BRIEF.md
# Buffered synchronous serial receiver

This block receives a clocked serial stream on one data pin and packs it into 4-bit or 8-bit words. The shift clock either comes from an internal divider of the system clock, driven out on `sck_o`, or from an external shift clock that is resynchronised into the system clock domain. Each finished word is written into the next register of a small buffer bank. When the programmed number of words has arrived, the block raises a one-cycle buffer-full interrupt and wraps its write index back to the first register.

Software reads the buffer registers from `buf_data_o` and signals each read with a per-register strobe. Overrun is handled according to the clock source. With the internal clock, a word that completes before any buffer has been read since the last buffer-full event is held back and the shift clock is frozen until a read arrives. With an external clock, the sender cannot be paused, so that word is dropped and reception ends. Reception can end gracefully at a word boundary or at once through an inhibit input. The busy flag shows whether reception is still active.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, `busy_o` and `irq_o` are 0, `sck_o` is 1 and every buffer register reads 0.
- R2: Reception starts, with `busy_o` high one cycle later, only on a 0-to-1 change of `start_i` while `rx_mode_i` is 1 and `inhibit_i` is 0. Starting also resets the write index to buffer 0.
- R3: With `ext_sel_i`=0 and reception active, `sck_o` alternates between DIV cycles low and DIV cycles high, starting from high. `sdi_i` is sampled at each rising edge of `sck_o`, and the first bit received becomes bit 0 of the word (LSB first).
- R4: With `wide_i`=1 a word is 8 bits. With `wide_i`=0 it is 4 bits, placed in bits [3:0] with bits [7:4] zero.
- R5: The k-th word after a start or after a buffer-full event is written to buffer k. Buffer b appears on `buf_data_o[8b+7:8b]`.
- R6: When the word numbered `word_cnt_i`+1 (encoding 0..7 means 1..8 words) is written, `irq_o` pulses high for exactly one cycle on the following cycle, and the next word goes to buffer 0.
- R7: With the internal clock, if a word completes while no read strobe has been seen since the last buffer-full event, the word is not written. `sck_o` stays high until any bit of `rd_stb_i` is asserted, including the strobe of a buffer that is not in use. The held word is then written and the clock resumes.
- R8: If at least one read strobe arrived after the last buffer-full event, the next word is written without any wait.
- R9: With `ext_sel_i`=1, each rising edge of `sck_ext_i` samples `sdi_i`, after both pass a two-flop synchroniser, and `sck_o` stays high.
- R10: With the external clock, a word that completes while no read strobe has been seen since the last buffer-full event is discarded, and `busy_o` drops.
- R11: When `start_i` goes low during reception, the word in progress is completed and written, and `busy_o` then drops. If no bits of a word are in progress, `busy_o` drops on the next cycle.
- R12: `inhibit_i`=1 clears `busy_o` on the next cycle, discards any partial or held word, and returns `sck_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_mode_i | input | 1 | Block configured for receive |
| start_i | input | 1 | Start / run request (level; rising edge starts) |
| inhibit_i | input | 1 | Immediate end of reception |
| wide_i | input | 1 | 1: 8-bit words, 0: 4-bit words |
| ext_sel_i | input | 1 | 1: external shift clock, 0: internal divider |
| word_cnt_i | input | $clog2(NBUF) | Words per buffer-full event, minus one |
| sck_ext_i | input | 1 | External shift clock |
| sdi_i | input | 1 | Serial data in |
| rd_stb_i | input | NBUF | One-cycle read strobe per buffer register |
| sck_o | output | 1 | Internal shift clock (idles high) |
| buf_data_o | output | 8*NBUF | Buffer register contents |
| irq_o | output | 1 | Buffer-full interrupt pulse |
| busy_o | output | 1 | Reception active |

## Verification
The hardest state to reach is the internal-clock automatic wait. It needs a buffer-full event and then a complete further word with no read in between. The release also has to come from the strobe of a buffer that holds no data. The bench uses a one-word batch of 4-bit words, lets a second word complete with no read, and holds the data pin idle while it checks that `sck_o` stays high and that buffer 0 is unchanged. It then strobes buffer 5 and checks that the held word lands in buffer 0. The external overrun is reached the same way, by sending a second word while the first is still unread.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned NIB_W  = 4;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ssrx_clkgen.sv
module ssrx_clkgen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ext_sel_i,
  input  logic sck_ext_i,
  input  logic sdi_i,
  output logic sck_o,
  output logic smp_o,
  output logic bit_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_q;
  logic          sck_q;
  logic [2:0]    ext_q;
  logic [1:0]    sdi_q;
  logic          tick;

  assign tick = (div_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b1;
      ext_q <= '0;
      sdi_q <= '0;
    end else begin
      ext_q <= {ext_q[1:0], sck_ext_i};
      sdi_q <= {sdi_q[0], sdi_i};
      if (!run_i) begin
        div_q <= '0;
        sck_q <= 1'b1;
      end else if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // rising edge of internal clock or of synchronised external clock
  assign smp_o = ext_sel_i ? (ext_q[1] & ~ext_q[2]) : (run_i & tick & ~sck_q);
  assign bit_o = ext_sel_i ? sdi_q[1] : sdi_i;
  assign sck_o = sck_q;

  a_r3_sample_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_o && !ext_sel_i) |=> sck_o);
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter
  import ssrx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  smp_i,
  input  logic  bit_i,
  input  logic  wide_i,
  output logic  done_o,
  output logic  mid_o,
  output word_t word_o
);
  word_t      sr_q, sr_n;
  logic [2:0] bcnt_q;
  logic [2:0] last;

  assign last   = wide_i ? 3'd7 : 3'd3;
  assign sr_n   = {bit_i, sr_q[WORD_W-1:1]};
  assign word_o = wide_i ? sr_n : {{(WORD_W-NIB_W){1'b0}}, sr_n[WORD_W-1:WORD_W-NIB_W]};
  assign done_o = smp_i && !clr_i && (bcnt_q >= last);
  assign mid_o  = (bcnt_q != 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (clr_i) begin
      bcnt_q <= '0;
    end else if (smp_i) begin
      sr_q   <= sr_n;
      bcnt_q <= done_o ? 3'd0 : bcnt_q + 3'd1;
    end
  end

  a_r4_word_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mid_o);
  a_r4_bit_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !clr_i && !done_o) |=> mid_o);
endmodule

// File: rtl/ssrx_bufbank.sv
module ssrx_bufbank
  import ssrx_pkg::*;
#(
  parameter int unsigned NBUF  = 8,
  parameter int unsigned IDX_W = $clog2(NBUF)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  word_t                  wr_data_i,
  input  logic [IDX_W-1:0]       word_cnt_i,
  input  logic [NBUF-1:0]        rd_stb_i,
  output logic [NBUF*WORD_W-1:0] buf_o,
  output logic                   irq_o,
  output logic                   pend_o
);
  logic [IDX_W-1:0] idx_q;
  logic             irq_q, pend_q;
  logic             last, any_rd;

  assign last   = (idx_q == word_cnt_i);
  assign any_rd = |rd_stb_i;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    word_t buf_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          buf_q <= '0;
      else if (wr_i && idx_q == IDX_W'(g))  buf_q <= wr_data_i;
    end
    assign buf_o[g*WORD_W +: WORD_W] = buf_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      idx_q  <= '0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q <= wr_i & last;
      if (wr_i) idx_q <= last ? '0 : idx_q + 1'b1;
      if (wr_i && last) pend_q <= 1'b1;
      else if (any_rd)  pend_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;

  a_r6_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_irq_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wr_i));
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import ssrx_pkg::*;
#(
  parameter int unsigned DIV   = 4,
  parameter int unsigned NBUF  = 8,
  localparam int unsigned IDX_W = $clog2(NBUF)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rx_mode_i,
  input  logic                   start_i,
  input  logic                   inhibit_i,
  input  logic                   wide_i,
  input  logic                   ext_sel_i,
  input  logic [IDX_W-1:0]       word_cnt_i,
  input  logic                   sck_ext_i,
  input  logic                   sdi_i,
  input  logic [NBUF-1:0]        rd_stb_i,
  output logic                   sck_o,
  output logic [NBUF*WORD_W-1:0] buf_data_o,
  output logic                   irq_o,
  output logic                   busy_o
);
  logic  busy_q, wait_q, stop_q, start_q;
  word_t hold_q;
  logic  run, smp_raw, smp_g, bit_s, done, mid, pend, any_rd;
  logic  go, stop_req, commit;
  word_t word, wr_data;

  assign any_rd   = |rd_stb_i;
  assign go       = rx_mode_i & start_i & ~start_q & ~inhibit_i & ~busy_q;
  assign stop_req = stop_q | ~start_i;
  assign run      = busy_q & ~wait_q & ~ext_sel_i;
  assign smp_g    = smp_raw & busy_q & ~wait_q & ~inhibit_i;

  ssrx_clkgen #(.DIV(DIV)) u_clk (
    .clk_i, .rst_ni, .run_i(run), .ext_sel_i, .sck_ext_i, .sdi_i,
    .sck_o, .smp_o(smp_raw), .bit_o(bit_s)
  );

  ssrx_shifter u_sh (
    .clk_i, .rst_ni, .clr_i(go | inhibit_i), .smp_i(smp_g), .bit_i(bit_s),
    .wide_i, .done_o(done), .mid_o(mid), .word_o(word)
  );

  always_comb begin
    commit  = 1'b0;
    wr_data = word;
    if (busy_q && !inhibit_i) begin
      if (wait_q) begin
        if (any_rd) begin
          commit  = 1'b1;
          wr_data = hold_q;
        end
      end else if (done && (!pend || any_rd)) begin
        commit = 1'b1;
      end
    end
  end

  ssrx_bufbank #(.NBUF(NBUF), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(go), .wr_i(commit), .wr_data_i(wr_data),
    .word_cnt_i, .rd_stb_i, .buf_o(buf_data_o), .irq_o, .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wait_q  <= 1'b0;
      stop_q  <= 1'b0;
      start_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      start_q <= start_i;
      if (inhibit_i) begin
        busy_q <= 1'b0;
        wait_q <= 1'b0;
        stop_q <= 1'b0;
      end else if (go) begin
        busy_q <= 1'b1;
        wait_q <= 1'b0;
        stop_q <= 1'b0;
      end else if (busy_q) begin
        if (!start_i) stop_q <= 1'b1;
        if (wait_q) begin
          if (any_rd) begin
            wait_q <= 1'b0;
            if (stop_req) busy_q <= 1'b0;
          end
        end else if (done) begin
          if (commit) begin
            if (stop_req) busy_q <= 1'b0;
          end else if (ext_sel_i) begin
            busy_q <= 1'b0;          // external overrun: drop and end
          end else begin
            wait_q <= 1'b1;          // internal overrun: freeze clock
            hold_q <= word;
          end
        end else if (stop_req && !mid) begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o = busy_q;

  a_r12_inhibit_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !busy_o);
  a_r7_wait_holds_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> sck_o);
  a_r10_no_ext_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_q) |-> !$past(ext_sel_i));
  a_r9_ext_clock_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && $past(ext_sel_i)) |-> sck_o);
endmodule

// File: tb/sync_serial_rx_tb.sv
module sync_serial_rx_tb_top;
  localparam int CLK_P = 10;
  localparam int DIV   = 3;
  localparam int NBUF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_mode = 0, start = 0, inhibit = 0, wide = 1, ext_sel = 0;
  logic [2:0] word_cnt = 0;
  logic sck_ext = 1, sdi = 0;
  logic [NBUF-1:0] rd_stb = 0;
  logic sck;
  logic [NBUF*8-1:0] bufs;
  logic irq, busy;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit sck_low_seen = 0, done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_serial_rx #(.DIV(DIV), .NBUF(NBUF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_mode_i(rx_mode), .start_i(start),
    .inhibit_i(inhibit), .wide_i(wide), .ext_sel_i(ext_sel), .word_cnt_i(word_cnt),
    .sck_ext_i(sck_ext), .sdi_i(sdi), .rd_stb_i(rd_stb), .sck_o(sck),
    .buf_data_o(bufs), .irq_o(irq), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (!sck) sck_low_seen = 1;
  end

  function automatic logic [7:0] buf_at(int b);
    return bufs[8*b +: 8];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic int_bit(logic b);
    do @(negedge clk); while (sck !== 1'b0);
    sdi = b;
    do @(negedge clk); while (sck !== 1'b1);
  endtask

  task automatic int_word(logic [7:0] v, int n);
    for (int i = 0; i < n; i++) int_bit(v[i]);
  endtask

  task automatic ext_word(logic [7:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sdi = v[i]; sck_ext = 0; cyc(4);
      sck_ext = 1; cyc(4);
    end
  endtask

  task automatic begin_rx();
    start = 0; cyc(1);
    start = 1; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "sck", sck, 1);
    chk("R1", "buffers", 32'(|bufs), 0);
  endtask

  task automatic t_no_mode();
    rx_mode = 0; begin_rx(); cyc(2);
    chk("R2", "busy without receive mode", busy, 0);
    start = 0; rx_mode = 1; cyc(1);
  endtask

  task automatic t_int_two_words();
    int i0;
    wide = 1; word_cnt = 1; ext_sel = 0;
    i0 = irq_cnt;
    begin_rx();
    chk("R2", "busy after start", busy, 1);
    int_word(8'hA5, 8);
    int_word(8'h3C, 8);
    start = 0; cyc(1);
    chk("R11", "idle stop ends at once", busy, 0);
    chk("R5", "buffer 0", buf_at(0), 8'hA5);
    chk("R5", "buffer 1", buf_at(1), 8'h3C);
    chk("R6", "one irq for two words", irq_cnt - i0, 1);
  endtask

  task automatic t_auto_wait();
    int i0;
    wide = 0; word_cnt = 0;
    i0 = irq_cnt;
    begin_rx();
    int_word(8'h09, 4);
    cyc(1);
    chk("R4", "nibble in low bits", buf_at(0), 8'h09);
    chk("R6", "irq for one-word batch", irq_cnt - i0, 1);
    int_word(8'h06, 4);
    sck_low_seen = 0;
    cyc(20);
    chk("R7", "clock frozen", 32'(sck_low_seen), 0);
    chk("R7", "held word not written", buf_at(0), 8'h09);
    chk("R7", "still busy in wait", busy, 1);
    rd_stb = 8'h20; cyc(1); rd_stb = 0; cyc(1);
    chk("R7", "held word written after read", buf_at(0), 8'h06);
    chk("R7", "irq after release", irq_cnt - i0, 2);
    rd_stb = 8'h01; cyc(1); rd_stb = 0;
    int_word(8'h03, 4);
    chk("R8", "word written without wait", buf_at(0), 8'h03);
    start = 0; cyc(1);
    chk("R11", "stop after nibble", busy, 0);
  endtask

  task automatic t_graceful();
    int i0;
    wide = 1; word_cnt = 7;
    i0 = irq_cnt;
    begin_rx();
    int_word(8'h03, 4);
    start = 0; cyc(1);
    chk("R11", "busy kept mid-word", busy, 1);
    int_word(8'h0C, 4);
    chk("R11", "busy cleared after word", busy, 0);
    chk("R11", "finished word stored", buf_at(0), 8'hC3);
    chk("R6", "no irq before count", irq_cnt - i0, 0);
  endtask

  task automatic t_inhibit();
    int lo;
    wide = 1; word_cnt = 0;
    begin_rx();
    do @(negedge clk); while (sck !== 1'b0);
    lo = 0;
    while (sck === 1'b0) begin lo++; @(negedge clk); end
    chk("R3", "low phase cycles", lo, DIV);
    int_word(8'h07, 3);
    inhibit = 1; cyc(1);
    chk("R12", "busy dropped", busy, 0);
    cyc(3);
    chk("R12", "clock idle high", sck, 1);
    chk("R12", "partial word discarded", buf_at(0), 8'hC3);
    inhibit = 0; start = 0; cyc(2);
  endtask

  task automatic t_external();
    int i0;
    ext_sel = 1; wide = 1; word_cnt = 0;
    i0 = irq_cnt;
    begin_rx();
    sck_low_seen = 0;
    ext_word(8'h5A, 8);
    chk("R9", "external word", buf_at(0), 8'h5A);
    chk("R9", "internal clock idle", 32'(sck_low_seen), 0);
    chk("R6", "irq external", irq_cnt - i0, 1);
    ext_word(8'hFF, 8);
    chk("R10", "overrun ends reception", busy, 0);
    chk("R10", "overrun word dropped", buf_at(0), 8'h5A);
    start = 0; ext_sel = 0; cyc(2);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(4);
    t_reset();
    rst_n = 1; rx_mode = 1; cyc(2);
    t_no_mode();
    t_int_two_words();
    t_auto_wait();
    t_graceful();
    t_inhibit();
    t_external();
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule